// File: doc/BRIEF.md
# Tuner Synthesizer Control Slave

This block is a two-wire serial bus (I2C) slave that keeps the programming state of a tuner's frequency synthesizer. A bus master writes a short frame to set the main and swallow divide ratios, the charge-pump settings, the reference-divider choice and four band-select outputs. A read returns one status byte that reports whether a power-on reset has happened since the last read and whether the loop is locked.

The clock and data lines are modelled as open-drain wires. A fast system clock samples them, so SCL and SDA are plain inputs. The slave pulls SDA low by raising `sda_oe_o`. The two low address bits come from a strap input, which lets up to four such slaves share one bus.

Each data byte is classified by its leading bit and not through a register pointer. A byte that opens a pair and starts with 0 is divider byte 1, and the byte after it is divider byte 2. A byte that opens a pair and starts with 1 is the control byte, and the byte after it is the band byte. Fields reach the outputs only once their byte has been acknowledged.

Top module: `tuner_pll_ctl`

## Requirements
- R1: The slave acknowledges an address byte equal to {1,1,0,0,0,addr_sel_i[1],addr_sel_i[0],rw}. If the address does not match it sends no acknowledge and ignores the rest of the frame until the next START or STOP.
- R2: A write byte that opens a pair with bit 7 = 0 loads its bits 6..0 into main_div_o[9:3]. The next byte loads main_div_o[2:0] from its bits 7..5 and swallow_o from its bits 4..0.
- R3: A byte that opens a pair with bit 7 = 1 is the control byte. Bit 6 sets cp_hi_o, bit 5 sets test_o, bit 4 sets cp_off_o and bit 0 sets vout_off_o.
- R4: The byte after a control byte sets band_o, ordered {fm-trap, uhf, vhf-high, vhf-low}. Vhf-low is byte bit 0 and vhf-high is byte bit 1. With BAND_SWAP = 0, uhf is bit 3 and fm-trap is bit 2. With BAND_SWAP = 1, those two are exchanged.
- R5: Pair classification restarts at every START. A frame may therefore begin directly with a control byte, and the divider fields then stay unchanged.
- R6: When div_mode_i = 1 (14-bit divider), main_div_o[9] is written as 0 whatever the written bit is.
- R7: When div_mode_i = 4 (switchable reference), control byte bits 2 and 1 load ref_sel_o[1:0]. In any other mode ref_sel_o keeps its value.
- R8: After address {1100_0,sel,1}, the slave returns the status byte {1, pr, fl, 1,1,1,0,0} MSB first. pr is 1 after reset and clears once a status byte has been fully read.
- R9: The fl bit equals lock_i as seen when the status byte is loaded for sending.
- R10: A STOP or repeated START ends a frame at any point. Bytes already acknowledged stay applied, and a partly received byte is discarded.
- R11: sda_oe_o changes only while SCL is low.
- R12: Reset clears every control output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Low two address bits |
| div_mode_i | input | 3 | Divider mode: 1 = 14-bit, 4 = switchable reference, others plain |
| lock_i | input | 1 | Loop lock indication |
| main_div_o | output | 10 | Main divide ratio |
| swallow_o | output | 5 | Swallow count |
| cp_hi_o | output | 1 | High charge-pump current |
| test_o | output | 1 | Test mode |
| cp_off_o | output | 1 | Charge pump disabled |
| vout_off_o | output | 1 | Varicap drive disabled |
| ref_sel_o | output | 2 | Reference divider select |
| band_o | output | 4 | Band outputs {fm-trap, uhf, vhf-high, vhf-low} |

## Verification
The first write is a full four-byte frame with asymmetric field values, so a swapped or shifted field shows up as a wrong output. Further frames start with the control byte, cut off after a single divider byte, stop in the middle of a byte, or break the frame with a repeated START. Together these separate leading-bit routing from positional routing and show whether discarded data ever reaches an output. Status reads with lock high and lock low, before and after the first read, separate the power-on flag from the lock flag. A second instance built with the band swap, and a frame sent to a non-matching address, exercise address decode and the variant mapping.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int BYTE_W = 8;
  localparam int BAND_N = 4;
  localparam logic [2:0] MODE_NARROW = 3'd1;
  localparam logic [2:0] MODE_EXTREF = 3'd4;
  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_AACK, L_WDAT, L_WACK, L_RDAT, L_RACK, L_SKIP
  } link_st_t;
endpackage

// File: rtl/tpc_pin_sync.sv
module tpc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_hi    = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_hi & ~scl_d;
  assign scl_fall  = ~scl_hi & scl_d;
  assign start_det = scl_hi & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_hi & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/tpc_link.sv
module tpc_link import tpc_pkg::*; #(
  parameter logic [BYTE_W-4:0] ADDR_HI = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic [1:0]        addr_sel,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              frm_start,
  output logic              rd_done
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  link_st_t          st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              mack;

  always_ff @(posedge clk) begin
    wr_stb    <= 1'b0;
    rd_done   <= 1'b0;
    frm_start <= 1'b0;
    if (rst) begin
      st      <= L_IDLE;
      cnt     <= '0;
      sh      <= '0;
      sda_oe  <= 1'b0;
      mack    <= 1'b0;
      wr_byte <= '0;
    end else if (start_det) begin
      st        <= L_ADDR;
      cnt       <= '0;
      sda_oe    <= 1'b0;
      frm_start <= 1'b1;
    end else if (stop_det) begin
      st     <= L_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        L_ADDR, L_WDAT: begin
          if (scl_rise && cnt != FULL) begin
            sh  <= {sh[BYTE_W-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            if (st == L_WDAT) begin
              sda_oe <= 1'b1;
              st     <= L_WACK;
            end else if (sh[BYTE_W-1:1] == {ADDR_HI, addr_sel}) begin
              sda_oe <= 1'b1;
              st     <= L_AACK;
            end else begin
              st <= L_SKIP;
            end
          end
        end
        L_AACK: if (scl_fall) begin
          cnt <= '0;
          if (sh[0]) begin
            sh     <= status_byte;
            sda_oe <= ~status_byte[BYTE_W-1];
            st     <= L_RDAT;
          end else begin
            sda_oe <= 1'b0;
            st     <= L_WDAT;
          end
        end
        L_WACK: if (scl_fall) begin
          sda_oe  <= 1'b0;
          wr_stb  <= 1'b1;
          wr_byte <= sh;
          cnt     <= '0;
          st      <= L_WDAT;
        end
        L_RDAT: if (scl_fall) begin
          if (cnt == LAST) begin
            sda_oe <= 1'b0;
            st     <= L_RACK;
          end else begin
            sh     <= {sh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~sh[BYTE_W-2];
            cnt    <= cnt + 1'b1;
          end
        end
        L_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_lvl;
          end else if (scl_fall) begin
            rd_done <= 1'b1;
            cnt     <= '0;
            if (mack) begin
              sh     <= status_byte;
              sda_oe <= ~status_byte[BYTE_W-1];
              st     <= L_RDAT;
            end else begin
              st <= L_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tpc_regs.sv
module tpc_regs import tpc_pkg::*; #(
  parameter int MAIN_W    = 10,
  parameter int SWAL_W    = 5,
  parameter bit BAND_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              frm_start,
  input  logic              rd_done,
  input  logic              lock_i,
  input  logic [2:0]        div_mode_i,
  output logic [BYTE_W-1:0] status_byte,
  output logic [MAIN_W-1:0] main_div_o,
  output logic [SWAL_W-1:0] swallow_o,
  output logic              cp_hi_o,
  output logic              test_o,
  output logic              cp_off_o,
  output logic              vout_off_o,
  output logic [1:0]        ref_sel_o,
  output logic [BAND_N-1:0] band_o
);
  localparam int LO_W = BYTE_W - SWAL_W;
  localparam int HI_W = MAIN_W - LO_W;

  logic              second_q, band_next_q, pr_q;
  logic [HI_W-1:0]   hi_bits;
  logic [BAND_N-1:0] band_dec;

  always_comb begin
    hi_bits = wr_byte[HI_W-1:0];
    if (div_mode_i == MODE_NARROW) hi_bits[HI_W-1] = 1'b0;
  end

  generate
    if (BAND_SWAP) begin : g_swap
      assign band_dec = {wr_byte[3], wr_byte[2], wr_byte[1], wr_byte[0]};
    end else begin : g_std
      assign band_dec = {wr_byte[2], wr_byte[3], wr_byte[1], wr_byte[0]};
    end
  endgenerate

  assign status_byte = {1'b1, pr_q, lock_i, 5'b11100};

  always_ff @(posedge clk) begin
    if (rst) begin
      second_q    <= 1'b0;
      band_next_q <= 1'b0;
      pr_q        <= 1'b1;
      main_div_o  <= '0;
      swallow_o   <= '0;
      cp_hi_o     <= 1'b0;
      test_o      <= 1'b0;
      cp_off_o    <= 1'b0;
      vout_off_o  <= 1'b0;
      ref_sel_o   <= '0;
      band_o      <= '0;
    end else begin
      if (frm_start) second_q <= 1'b0;
      if (rd_done) pr_q <= 1'b0;
      if (wr_stb) begin
        if (!second_q) begin
          second_q    <= 1'b1;
          band_next_q <= wr_byte[BYTE_W-1];
          if (wr_byte[BYTE_W-1]) begin
            cp_hi_o    <= wr_byte[6];
            test_o     <= wr_byte[5];
            cp_off_o   <= wr_byte[4];
            vout_off_o <= wr_byte[0];
            if (div_mode_i == MODE_EXTREF) ref_sel_o <= wr_byte[2:1];
          end else begin
            main_div_o[MAIN_W-1:LO_W] <= hi_bits;
          end
        end else begin
          second_q <= 1'b0;
          if (band_next_q) band_o <= band_dec;
          else {main_div_o[LO_W-1:0], swallow_o} <= wr_byte;
        end
      end
    end
  end
endmodule

// File: rtl/tuner_pll_ctl.sv
module tuner_pll_ctl import tpc_pkg::*; #(
  parameter int MAIN_W      = 10,
  parameter int SWAL_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter bit BAND_SWAP   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        addr_sel_i,
  input  logic [2:0]        div_mode_i,
  input  logic              lock_i,
  output logic [MAIN_W-1:0] main_div_o,
  output logic [SWAL_W-1:0] swallow_o,
  output logic              cp_hi_o,
  output logic              test_o,
  output logic              cp_off_o,
  output logic              vout_off_o,
  output logic [1:0]        ref_sel_o,
  output logic [BAND_N-1:0] band_o
);
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb, frm_start, rd_done;
  logic [BYTE_W-1:0] wr_byte, status_byte;

  tpc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  tpc_link u_link (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
    .addr_sel(addr_sel_i), .status_byte(status_byte), .sda_oe(sda_oe_o),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .frm_start(frm_start), .rd_done(rd_done)
  );

  tpc_regs #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .BAND_SWAP(BAND_SWAP)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte), .frm_start(frm_start),
    .rd_done(rd_done), .lock_i(lock_i), .div_mode_i(div_mode_i), .status_byte(status_byte),
    .main_div_o(main_div_o), .swallow_o(swallow_o), .cp_hi_o(cp_hi_o), .test_o(test_o),
    .cp_off_o(cp_off_o), .vout_off_o(vout_off_o), .ref_sel_o(ref_sel_o), .band_o(band_o)
  );
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker import tpc_pkg::*; #(
  parameter int MAIN_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [2:0]        div_mode_i,
  input logic [MAIN_W-1:0] main_div_o,
  input logic [1:0]        ref_sel_o,
  input logic [BAND_N-1:0] band_o
);
  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_i);

  a_r10_band_commit_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(band_o) |-> !scl_i);

  a_r2_divider_commit_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(main_div_o) |-> !scl_i);

  a_r6_narrow_top_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(main_div_o[MAIN_W-1]) |-> ($past(div_mode_i) != MODE_NARROW));

  a_r7_ref_only_extended: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_sel_o) |-> ($past(div_mode_i) == MODE_EXTREF));

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (band_o == '0 && main_div_o == '0 && ref_sel_o == '0));
endmodule

bind tuner_pll_ctl tpc_checker #(.MAIN_W(MAIN_W)) u_tpc_checker (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o), .div_mode_i(div_mode_i),
  .main_div_o(main_div_o), .ref_sel_o(ref_sel_o), .band_o(band_o)
);

// File: tb/tuner_pll_ctl_bench.sv
`timescale 1ns/1ps
module tuner_pll_ctl_bench;
  localparam int HP = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic lock = 1'b0;
  logic [2:0] mode = 3'd0;
  wire  sda_line;
  int checks = 0;
  int errors = 0;
  int r11_viol = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  logic oe_a, oe_b;
  logic [9:0] main_a, main_b;
  logic [4:0] sw_a, sw_b;
  logic cp_a, t_a, cd_a, os_a, cp_b, t_b, cd_b, os_b;
  logic [1:0] ref_a, ref_b;
  logic [3:0] band_a, band_b;

  assign sda_line = ~(m_low | oe_a | oe_b);

  tuner_pll_ctl u_tuner_pll_ctl (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(oe_a),
    .addr_sel_i(2'b01), .div_mode_i(mode), .lock_i(lock), .main_div_o(main_a),
    .swallow_o(sw_a), .cp_hi_o(cp_a), .test_o(t_a), .cp_off_o(cd_a), .vout_off_o(os_a),
    .ref_sel_o(ref_a), .band_o(band_a)
  );

  tuner_pll_ctl #(.BAND_SWAP(1'b1)) u_tuner_pll_ctl_swp (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(oe_b),
    .addr_sel_i(2'b11), .div_mode_i(mode), .lock_i(lock), .main_div_o(main_b),
    .swallow_o(sw_b), .cp_hi_o(cp_b), .test_o(t_b), .cp_off_o(cd_b), .vout_off_o(os_b),
    .ref_sel_o(ref_b), .band_o(band_b)
  );

  // R11 monitor: data line drive must not move while the clock line is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && (oe_a != oe_prev) && m_scl) r11_viol++;
    oe_prev <= oe_a;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard for read results
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_byte;
  event       rd_ev;

  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R8: actual %0h expected nothing queued", got_byte);
    end else begin
      check(tag_q.pop_front(), {24'd0, got_byte}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic bus_wait();
    repeat (HP) @(negedge clk);
  endtask

  task automatic do_start();
    m_low = 1'b0; bus_wait();
    m_scl = 1'b1; bus_wait();
    m_low = 1'b1; bus_wait();
    m_scl = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic do_stop();
    m_low = 1'b1; bus_wait();
    m_scl = 1'b1; bus_wait();
    m_low = 1'b0; bus_wait();
  endtask

  task automatic clock_bit(input logic b, output logic r);
    m_low = ~b; bus_wait();
    m_scl = 1'b1; bus_wait();
    r = sda_line;
    m_scl = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic read_status(input logic [7:0] exp, input string tag);
    logic r;
    bit ack;
    logic [7:0] b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    do_start();
    write_byte({5'b11000, 2'b01, 1'b1}, ack);
    check("R1 read address ack", {31'd0, ack}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, r);
      b = {b[6:0], r};
    end
    clock_bit(1'b1, r);
    got_byte = b;
    ->rd_ev;
    do_stop();
  endtask

  task automatic wr_frame(input logic [1:0] sel, input int n,
                          input logic [7:0] b0, b1, b2, b3, output bit all_ack);
    bit ack;
    logic [7:0] bytes [4];
    bytes = '{b0, b1, b2, b3};
    do_start();
    write_byte({5'b11000, sel, 1'b0}, ack);
    all_ack = ack;
    for (int i = 0; i < n; i++) begin
      write_byte(bytes[i], ack);
      all_ack &= ack;
    end
    do_stop();
  endtask

  initial begin
    bit ok;
    logic r;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R12 reset state
    check("R12 main reset", {22'd0, main_a}, 32'd0);
    check("R12 band reset", {28'd0, band_a}, 32'd0);
    check("R12 ref/ctrl reset", {26'd0, ref_a, cp_a, t_a, cd_a, os_a}, 32'd0);

    // R8 R9 status after reset, lock low: {1,1,0,11100}
    read_status(8'hDC, "R8 R9 status after reset");
    lock = 1'b1;
    // R8 pr cleared after one read, R9 fl follows lock
    read_status(8'hBC, "R8 R9 pr cleared, lock high");

    // R2 R3 R4 R7 full frame in plain mode
    wr_frame(2'b01, 4, 8'h55, 8'hB3, 8'hD7, 8'h09, ok);
    check("R1 all bytes acked", {31'd0, ok}, 32'd1);
    check("R2 main divider", {22'd0, main_a}, 32'h2AD);
    check("R2 swallow", {27'd0, sw_a}, 32'h13);
    check("R3 control bits", {28'd0, cp_a, t_a, cd_a, os_a}, 32'b1011);
    check("R7 ref held in plain mode", {30'd0, ref_a}, 32'd0);
    check("R4 band mapping", {28'd0, band_a}, 32'b0101);

    // R5 frame opening with control byte
    wr_frame(2'b01, 2, 8'h80, 8'h06, 8'h00, 8'h00, ok);
    check("R5 band from control-first frame", {28'd0, band_a}, 32'b1010);
    check("R5 divider untouched", {22'd0, main_a}, 32'h2AD);
    check("R3 control cleared", {28'd0, cp_a, t_a, cd_a, os_a}, 32'd0);

    // R6 14-bit mode forces the top divider bit low
    mode = 3'd1;
    wr_frame(2'b01, 2, 8'h7F, 8'h00, 8'h00, 8'h00, ok);
    check("R6 top bit forced low", {22'd0, main_a}, 32'h1F8);

    // R7 switchable reference mode
    mode = 3'd4;
    wr_frame(2'b01, 1, 8'h84, 8'h00, 8'h00, 8'h00, ok);
    check("R7 ref loaded in extended mode", {30'd0, ref_a}, 32'd2);
    mode = 3'd0;
    wr_frame(2'b01, 1, 8'h82, 8'h00, 8'h00, 8'h00, ok);
    check("R7 ref held outside extended mode", {30'd0, ref_a}, 32'd2);

    // R10 stop after the first divider byte
    wr_frame(2'b01, 1, 8'h01, 8'h00, 8'h00, 8'h00, ok);
    check("R10 upper bits only", {22'd0, main_a}, 32'h008);

    // R10 partial byte before STOP is discarded
    do_start();
    write_byte({5'b11000, 2'b01, 1'b0}, ok);
    write_byte(8'h80, ok);
    for (int i = 0; i < 4; i++) clock_bit(1'b0, r);
    do_stop();
    check("R10 partial band byte dropped", {28'd0, band_a}, 32'b1010);

    // R5 R10 repeated START restarts pair classification
    do_start();
    write_byte({5'b11000, 2'b01, 1'b0}, ok);
    write_byte(8'h80, ok);
    do_start();
    write_byte({5'b11000, 2'b01, 1'b0}, ok);
    write_byte(8'h0F, ok);
    do_stop();
    check("R10 band kept over restart", {28'd0, band_a}, 32'b1010);
    check("R5 byte after restart is divider", {22'd0, main_a}, 32'h078);

    // R1 wrong address: no ack, nothing applied
    wr_frame(2'b10, 2, 8'h80, 8'h0F, 8'h00, 8'h00, ok);
    check("R1 foreign address not acked", {31'd0, ok}, 32'd0);
    check("R1 foreign frame ignored", {28'd0, band_a}, 32'b1010);

    // R4 swapped variant at its own address
    wr_frame(2'b11, 2, 8'h80, 8'h09, 8'h00, 8'h00, ok);
    check("R4 swapped band mapping", {28'd0, band_b}, 32'b1001);
    check("R1 other device untouched", {28'd0, band_a}, 32'b1010);

    // R9 lock low again, pr stays clear
    lock = 1'b0;
    read_status(8'h9C, "R8 R9 status lock low");

    check("R11 drive changes only with clock low", r11_viol, 32'd0);
    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule